// File: doc/BRIEF.md
# SD Command Issue and Interrupt Status Unit

This unit sits between a register bus and an abstract card command-line engine. Software loads an argument, then writes a command word whose flag bits choose the command's behaviour: whether a response is expected, whether it is long, whether the data path must go idle first, and whether a train of initialisation clocks is sent ahead of the command. The unit launches one command at a time. A start flag stays visible in the command word until the line engine accepts the command.

The unit also gathers event pulses from the line engine and the data path into a raw interrupt word. Software clears that word by writing ones to it. A mask register selects which raw bits reach the interrupt pin. A fixed error summary output reports any error-class raw bit, whatever the mask holds. Responses returned by the engine are captured into four response words. A read-only status word reflects the FIFO level flags and the busy flags.

Top module: `sdcmd_ctrl`

## Requirements
- R1: After reset, the raw, masked, command and response registers read zero, and irq, err_sum, eng_req and init_active are low.
- R2: Writing offset 0x18 with bit 31 set while no command is pending starts a command. Reads of 0x18 and the eng_cmd output then show the written word with bit 31 set, and eng_arg shows the value held at offset 0x1C.
- R3: Bit 31 of the command reads clear in the cycle after the engine accepts (eng_accept while eng_req is high). A command write that arrives while bit 31 is still set leaves the command register unchanged.
- R4: When command bit 15 is set, init_active is high and eng_req stays low until INIT_CLKS card_tick pulses have been counted. eng_req rises after the last of those pulses.
- R5: When command bit 13 is set, eng_req is held low while data_busy is high. When bit 13 is clear, data_busy has no effect on eng_req.
- R6: A cmd_done pulse sets raw bit 2. Response words are written only if command bit 6 was set. With bit 7 set, all four words load from resp_data, with offset 0x20 holding bits 31:0 and 0x2C holding bits 127:96. Otherwise only 0x20 loads, from bits 31:0, and the other words keep their values.
- R7: A data_over pulse sets raw bit 14 if the current command had bit 12 (auto-stop) set, and raw bit 3 if it did not.
- R8: evt_raw sets raw bits 1, 4-13, 15, 16, 30 and 31. Its bits 0, 2, 3, 14 and 17-29 are ignored.
- R9: Writing offset 0x38 clears each raw bit written as one, and all-ones clears the whole word. If a bit is set and cleared in the same cycle, the set takes precedence.
- R10: Offset 0x34 reads raw AND mask, where the mask is read/write at 0x30. irq is high exactly when that masked value is nonzero.
- R11: err_sum is high when raw AND 0xBFC2 is nonzero, regardless of the mask.
- R12: Offset 0x3C reads receive watermark at bit 0, transmit watermark at 1, FIFO empty at 2, FIFO full at 3, card present at 8, card data busy at 9 and data state machine busy at 10. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_req | output | 1 | Command request to the line engine |
| eng_cmd | output | 32 | Latched command word |
| eng_arg | output | 32 | Argument latched at launch |
| eng_accept | input | 1 | Engine takes the requested command |
| init_active | output | 1 | Initialisation clock train in progress |
| card_tick | input | 1 | One pulse per card clock period |
| cmd_done | input | 1 | Command (and response) complete pulse |
| resp_data | input | 128 | Response bits delivered with cmd_done |
| data_over | input | 1 | Data transfer finished pulse |
| evt_raw | input | 32 | Other event pulses, by raw bit position |
| fifo_rx_wm | input | 1 | Receive watermark reached |
| fifo_tx_wm | input | 1 | Transmit watermark reached |
| fifo_empty | input | 1 | FIFO empty |
| fifo_full | input | 1 | FIFO full |
| card_present | input | 1 | Card detected |
| card_busy | input | 1 | Card holds data line busy |
| data_busy | input | 1 | Data state machine busy |
| irq | output | 1 | OR of masked raw status |
| err_sum | output | 1 | Error summary |

## Verification
The in-line assertions check a set of properties on every cycle. A command write during a pending command never changes the latched word. An engine acceptance always clears the pending state. The initialisation counter never passes its limit. A short response never disturbs the upper response words. A write-one-to-clear with no concurrent event really clears. A concurrent event always survives. The error summary only rises after an error-class event. Other behaviours need the bench's scenarios to show them: the exact tick on which an initialisation train ends, the hold-off under data_busy, auto-stop steering the completion to bit 14, the response word ordering, the mask and error-summary combinations walked from the table, and the status bit placement.

// File: rtl/sdcmd_pkg.sv
// Shared constants for the SD command issue unit: register offsets,
// command flag positions, raw status positions and fixed masks.
package sdcmd_pkg;
    // register byte offsets
    localparam logic [7:0] OFS_CMD    = 8'h18;
    localparam logic [7:0] OFS_ARG    = 8'h1C;
    localparam logic [7:0] OFS_RESP0  = 8'h20;
    localparam logic [7:0] OFS_RESP1  = 8'h24;
    localparam logic [7:0] OFS_RESP2  = 8'h28;
    localparam logic [7:0] OFS_RESP3  = 8'h2C;
    localparam logic [7:0] OFS_MASK   = 8'h30;
    localparam logic [7:0] OFS_MSKD   = 8'h34;
    localparam logic [7:0] OFS_RAW    = 8'h38;
    localparam logic [7:0] OFS_STAT   = 8'h3C;

    // command flag positions
    localparam int CF_RESP  = 6;
    localparam int CF_LONG  = 7;
    localparam int CF_ASTOP = 12;
    localparam int CF_WAIT  = 13;
    localparam int CF_INIT  = 15;
    localparam int CF_START = 31;

    // raw status positions fed by dedicated inputs
    localparam int RS_CMD_DONE  = 2;
    localparam int RS_DATA_OVER = 3;
    localparam int RS_AUTO_DONE = 14;

    // error-class raw bits
    localparam logic [31:0] ERR_MASK = 32'hBFC2;
    // raw bits that the generic event input may set
    localparam logic [31:0] GEN_MASK = 32'hC001_BFF2;

    typedef enum logic [1:0] {SQ_IDLE, SQ_INIT, SQ_ISSUE} seq_state_t;
endpackage

// File: rtl/sdcmd_seq.sv
// Command sequencer: latches a command and its argument and, if asked,
// counts an initialisation clock train first. It then requests the line
// engine until the command is accepted.
// Assumes card_tick is a single-cycle pulse per card clock and
// INIT_CLKS >= 1.
module sdcmd_seq
    import sdcmd_pkg::*;
#(
    parameter int INIT_CLKS = 80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    input  logic [31:0] arg_in,
    input  logic        card_tick,
    input  logic        data_busy,
    input  logic        eng_accept,
    output logic [31:0] cmd_q,
    output logic [31:0] arg_q,
    output logic        busy,
    output logic        init_active,
    output logic        eng_req
);
    localparam int CNT_W = $clog2(INIT_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CLKS - 1);

    seq_state_t       st;
    logic [CNT_W-1:0] cnt;

    // state, latched command and init counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SQ_IDLE;
            cmd_q <= '0;
            arg_q <= '0;
            cnt   <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (cmd_wr) begin
                        cmd_q <= cmd_wdata;
                        if (cmd_wdata[CF_START]) begin
                            arg_q <= arg_in;
                            cnt   <= '0;
                            st    <= cmd_wdata[CF_INIT] ? SQ_INIT : SQ_ISSUE;
                        end
                    end
                end
                SQ_INIT: begin
                    if (card_tick) begin
                        if (cnt == CNT_LAST) st  <= SQ_ISSUE;
                        else                 cnt <= cnt + 1'b1;
                    end
                end
                SQ_ISSUE: begin
                    if (eng_req && eng_accept) st <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // request gating and status flags
    always_comb begin
        busy        = (st != SQ_IDLE);
        init_active = (st == SQ_INIT);
        eng_req     = (st == SQ_ISSUE) && !(cmd_q[CF_WAIT] && data_busy);
    end

    // R3
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(cmd_q));
    // R3
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_accept) |=> !busy);
    // R4
    init_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(INIT_CLKS));
endmodule

// File: rtl/sdcmd_resp.sv
// Response capture: four 32-bit words loaded on command completion.
// A long response fills all four words, a short one only word 0.
// Assumes resp_data is valid in the cycle cmd_done is high.
module sdcmd_resp #(
    parameter int NWORDS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_done,
    input  logic                 resp_en,
    input  logic                 resp_long,
    input  logic [32*NWORDS-1:0] resp_data,
    output logic [32*NWORDS-1:0] resp_q
);
    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        // per-word load: word 0 always, others only for long responses
        always_ff @(posedge clk) begin
            if (!rst_n)
                resp_q[32*i +: 32] <= '0;
            else if (cmd_done && resp_en && (resp_long || i == 0))
                resp_q[32*i +: 32] <= resp_data[32*i +: 32];
        end
    end

    // R6
    short_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !resp_long) |=> $stable(resp_q[32*NWORDS-1:32]));
endmodule

// File: rtl/sdcmd_irq.sv
// Interrupt status: raw word with write-one-to-clear (set wins), mask
// register, masked interrupt output and fixed error summary.
// Assumes set_vec is made of single-cycle event pulses.
module sdcmd_irq
    import sdcmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] set_vec,
    input  logic        clr_en,
    input  logic [31:0] clr_vec,
    input  logic        mask_wr,
    input  logic [31:0] mask_wdata,
    output logic [31:0] raw_q,
    output logic [31:0] mask_q,
    output logic        irq,
    output logic        err_sum
);
    logic [31:0] clr_eff;

    // select the clear pattern for this cycle
    always_comb clr_eff = clr_en ? clr_vec : '0;

    // raw status and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_eff) | set_vec;
            if (mask_wr) mask_q <= mask_wdata;
        end
    end

    // interrupt and error summary outputs
    always_comb begin
        irq     = |(raw_q & mask_q);
        err_sum = |(raw_q & ERR_MASK);
    end

    // R9
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && set_vec == '0) |=> ((raw_q & $past(clr_vec)) == '0));
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((raw_q & $past(set_vec)) == $past(set_vec)));
    // R11
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sum) |-> (($past(set_vec) & ERR_MASK) != '0));
endmodule

// File: rtl/sdcmd_ctrl.sv
// Top of the SD command issue unit: register decode, argument register,
// event steering into raw status, status word and read mux.
// Assumes a single-cycle write strobe and combinational reads.
module sdcmd_ctrl
    import sdcmd_pkg::*;
#(
    parameter int INIT_CLKS = 80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [7:0]   bus_addr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    output logic         eng_req,
    output logic [31:0]  eng_cmd,
    output logic [31:0]  eng_arg,
    input  logic         eng_accept,
    output logic         init_active,
    input  logic         card_tick,
    input  logic         cmd_done,
    input  logic [127:0] resp_data,
    input  logic         data_over,
    input  logic [31:0]  evt_raw,
    input  logic         fifo_rx_wm,
    input  logic         fifo_tx_wm,
    input  logic         fifo_empty,
    input  logic         fifo_full,
    input  logic         card_present,
    input  logic         card_busy,
    input  logic         data_busy,
    output logic         irq,
    output logic         err_sum
);
    logic [31:0]  arg_reg;
    logic         cmd_busy;
    logic [127:0] resp_q;
    logic [31:0]  raw_q, mask_q, set_vec, stat_word;

    // argument register
    always_ff @(posedge clk) begin
        if (!rst_n)                           arg_reg <= '0;
        else if (bus_wr && bus_addr == OFS_ARG) arg_reg <= bus_wdata;
    end

    sdcmd_seq #(.INIT_CLKS(INIT_CLKS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (bus_wr && bus_addr == OFS_CMD),
        .cmd_wdata   (bus_wdata),
        .arg_in      (arg_reg),
        .card_tick   (card_tick),
        .data_busy   (data_busy),
        .eng_accept  (eng_accept),
        .cmd_q       (eng_cmd),
        .arg_q       (eng_arg),
        .busy        (cmd_busy),
        .init_active (init_active),
        .eng_req     (eng_req)
    );

    sdcmd_resp #(.NWORDS(4)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_done  (cmd_done),
        .resp_en   (eng_cmd[CF_RESP]),
        .resp_long (eng_cmd[CF_LONG]),
        .resp_data (resp_data),
        .resp_q    (resp_q)
    );

    // steer events into raw status positions
    always_comb begin
        set_vec               = evt_raw & GEN_MASK;
        set_vec[RS_CMD_DONE]  = cmd_done;
        set_vec[RS_DATA_OVER] = data_over && !eng_cmd[CF_ASTOP];
        set_vec[RS_AUTO_DONE] = data_over && eng_cmd[CF_ASTOP];
    end

    sdcmd_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_en     (bus_wr && bus_addr == OFS_RAW),
        .clr_vec    (bus_wdata),
        .mask_wr    (bus_wr && bus_addr == OFS_MASK),
        .mask_wdata (bus_wdata),
        .raw_q      (raw_q),
        .mask_q     (mask_q),
        .irq        (irq),
        .err_sum    (err_sum)
    );

    // status word assembly
    always_comb begin
        stat_word     = '0;
        stat_word[0]  = fifo_rx_wm;
        stat_word[1]  = fifo_tx_wm;
        stat_word[2]  = fifo_empty;
        stat_word[3]  = fifo_full;
        stat_word[8]  = card_present;
        stat_word[9]  = card_busy;
        stat_word[10] = data_busy;
    end

    // register read mux
    always_comb begin
        case (bus_addr)
            OFS_CMD:   bus_rdata = {cmd_busy, eng_cmd[30:0]};
            OFS_ARG:   bus_rdata = arg_reg;
            OFS_RESP0: bus_rdata = resp_q[31:0];
            OFS_RESP1: bus_rdata = resp_q[63:32];
            OFS_RESP2: bus_rdata = resp_q[95:64];
            OFS_RESP3: bus_rdata = resp_q[127:96];
            OFS_MASK:  bus_rdata = mask_q;
            OFS_MSKD:  bus_rdata = raw_q & mask_q;
            OFS_RAW:   bus_rdata = raw_q;
            OFS_STAT:  bus_rdata = stat_word;
            default:   bus_rdata = '0;
        endcase
    end

    // R2
    req_means_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> eng_cmd[CF_START]);
endmodule

// File: tb/sdcmd_ctrl_bench.sv
`timescale 1ns/1ps
module sdcmd_ctrl_bench;
    localparam int INIT_CLKS = 80;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         eng_req, init_active, irq, err_sum;
    logic [31:0]  eng_cmd, eng_arg;
    logic         eng_accept = 1'b0, card_tick = 1'b0, cmd_done = 1'b0;
    logic         data_over = 1'b0;
    logic [127:0] resp_data = '0;
    logic [31:0]  evt_raw = '0;
    logic         fifo_rx_wm = 0, fifo_tx_wm = 0, fifo_empty = 0, fifo_full = 0;
    logic         card_present = 0, card_busy = 0, data_busy = 0;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sdcmd_ctrl #(.INIT_CLKS(INIT_CLKS)) u_sdcmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_req(eng_req),
        .eng_cmd(eng_cmd), .eng_arg(eng_arg), .eng_accept(eng_accept),
        .init_active(init_active), .card_tick(card_tick), .cmd_done(cmd_done),
        .resp_data(resp_data), .data_over(data_over), .evt_raw(evt_raw),
        .fifo_rx_wm(fifo_rx_wm), .fifo_tx_wm(fifo_tx_wm),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .card_present(card_present), .card_busy(card_busy),
        .data_busy(data_busy), .irq(irq), .err_sum(err_sum)
    );

    // table: event, mask, expected masked, expected irq, expected err
    localparam int NV = 10;
    localparam logic [31:0] T_EVT [NV] = '{32'h2, 32'h10, 32'h10, 32'h100,
        32'h4000_0000, 32'h8000, 32'h1_0000, 32'h400, 32'h1, 32'h4008};
    localparam logic [31:0] T_MASK [NV] = '{32'hFFFF_FFFF, 32'hFFFF, 32'h20,
        32'h0, 32'h4000_0000, 32'h8000, 32'h1_0000, 32'h0, 32'hFFFF_FFFF,
        32'hFFFF_FFFF};
    localparam logic [31:0] T_MSKD [NV] = '{32'h2, 32'h10, 32'h0, 32'h0,
        32'h4000_0000, 32'h8000, 32'h1_0000, 32'h0, 32'h0, 32'h0};
    localparam logic [NV-1:0] T_IRQ = 10'b00_0111_0011;
    localparam logic [NV-1:0] T_ERR = 10'b00_1010_1001;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic pulse_evt(input logic [31:0] v);
        @(negedge clk); evt_raw = v; @(negedge clk); evt_raw = '0;
    endtask
    task automatic accept();
        @(negedge clk); eng_accept = 1'b1; @(negedge clk); eng_accept = 1'b0;
    endtask
    task automatic tick();
        @(negedge clk); card_tick = 1'b1; @(negedge clk); card_tick = 1'b0;
    endtask
    task automatic done(input logic [127:0] r);
        @(negedge clk); cmd_done = 1'b1; resp_data = r;
        @(negedge clk); cmd_done = 1'b0;
    endtask
    task automatic dover();
        @(negedge clk); data_over = 1'b1; @(negedge clk); data_over = 1'b0;
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h38, v); check("R1 raw", v, 0);
        rd(8'h34, v); check("R1 masked", v, 0);
        rd(8'h18, v); check("R1 cmd", v, 0);
        rd(8'h20, v); check("R1 resp0", v, 0);
        check("R1 pins", {28'b0, irq, err_sum, eng_req, init_active}, 0);

        // R8 R9 R10 R11 table walk
        for (int i = 0; i < NV; i++) begin
            wr(8'h30, T_MASK[i]);
            pulse_evt(T_EVT[i]);
            rd(8'h34, v); check("R8 R10 masked", v, T_MSKD[i]);
            check("R10 irq", {31'b0, irq}, {31'b0, T_IRQ[i]});
            check("R11 err_sum", {31'b0, err_sum}, {31'b0, T_ERR[i]});
            wr(8'h38, 32'hFFFF_FFFF);
            rd(8'h38, v); check("R9 clear all", v, 0);
        end
        wr(8'h30, 32'h0);

        // R2 R3 short command
        wr(8'h1C, 32'h1234_5678);
        wr(8'h18, 32'h8000_0051);
        rd(8'h18, v); check("R2 start readback", v, 32'h8000_0051);
        check("R2 eng_req", {31'b0, eng_req}, 1);
        check("R2 eng_arg", eng_arg, 32'h1234_5678);
        wr(8'h18, 32'h8000_0005);
        rd(8'h18, v); check("R3 ignored write", v, 32'h8000_0051);
        accept();
        rd(8'h18, v); check("R3 start cleared", v, 32'h0000_0051);
        check("R3 req dropped", {31'b0, eng_req}, 0);

        // R6 short response
        done({32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111});
        rd(8'h20, v); check("R6 short resp0", v, 32'h1111_1111);
        rd(8'h24, v); check("R6 short resp1", v, 0);
        rd(8'h38, v); check("R6 cmd done bit", v, 32'h4);
        wr(8'h38, 32'hFFFF_FFFF);

        // R6 long response
        wr(8'h18, 32'h8000_00C2);
        accept();
        done({32'hA300_0000, 32'hA200_0000, 32'hA100_0000, 32'hA000_0000});
        rd(8'h20, v); check("R6 long resp0", v, 32'hA000_0000);
        rd(8'h24, v); check("R6 long resp1", v, 32'hA100_0000);
        rd(8'h28, v); check("R6 long resp2", v, 32'hA200_0000);
        rd(8'h2C, v); check("R6 long resp3", v, 32'hA300_0000);

        // R6 no response expected
        wr(8'h18, 32'h8000_0000);
        accept();
        done({4{32'hFFFF_FFFF}});
        rd(8'h20, v); check("R6 no-resp keeps", v, 32'hA000_0000);
        rd(8'h38, v); check("R6 done without resp", v, 32'h4);
        wr(8'h38, 32'hFFFF_FFFF);

        // R4 init sequence
        wr(8'h18, 32'h8000_8000);
        check("R4 init active", {31'b0, init_active}, 1);
        check("R4 no req in init", {31'b0, eng_req}, 0);
        for (int k = 0; k < INIT_CLKS - 1; k++) tick();
        check("R4 req held before last tick", {31'b0, eng_req}, 0);
        tick();
        check("R4 req after last tick", {31'b0, eng_req}, 1);
        check("R4 init ended", {31'b0, init_active}, 0);
        accept();

        // R5 wait for previous
        @(negedge clk); data_busy = 1'b1;
        wr(8'h18, 32'h8000_2000);
        check("R5 held while busy", {31'b0, eng_req}, 0);
        data_busy = 1'b0; #1;
        check("R5 released", {31'b0, eng_req}, 1);
        accept();
        @(negedge clk); data_busy = 1'b1;
        wr(8'h18, 32'h8000_0000);
        check("R5 no wait flag", {31'b0, eng_req}, 1);
        accept();
        @(negedge clk); data_busy = 1'b0;

        // R7 auto-stop completion steering
        wr(8'h18, 32'h8000_1200);
        accept();
        dover();
        rd(8'h38, v); check("R7 auto done", v, 32'h4000);
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h18, 32'h8000_0200);
        accept();
        dover();
        rd(8'h38, v); check("R7 data over", v, 32'h8);
        wr(8'h38, 32'hFFFF_FFFF);

        // R9 partial clear and set-wins
        pulse_evt(32'h8012);
        wr(8'h38, 32'h10);
        rd(8'h38, v); check("R9 partial clear", v, 32'h8002);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h38; bus_wdata = 32'h2; evt_raw = 32'h2;
        @(negedge clk); bus_wr = 1'b0; evt_raw = '0;
        rd(8'h38, v); check("R9 set wins", v, 32'h8002);
        wr(8'h38, 32'hFFFF_FFFF);

        // R12 status word
        fifo_rx_wm = 1; fifo_full = 1; card_busy = 1;
        rd(8'h3C, v); check("R12 status a", v, 32'h209);
        fifo_rx_wm = 0; fifo_full = 0; card_busy = 0;
        fifo_tx_wm = 1; fifo_empty = 1; card_present = 1; data_busy = 1;
        rd(8'h3C, v); check("R12 status b", v, 32'h506);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule